// File: doc/BRIEF.md
# Cascaded Interrupt Vector Controller

This block joins two eight-input interrupt controllers into one sixteen-source interrupt unit. The secondary controller collects request lines 8 to 15 and feeds its combined request into input 2 of the primary controller. The primary controller resolves its own lines and that cascade input by fixed priority and raises a single interrupt output to the processor.

The processor answers the interrupt with two acknowledge pulses. The first pulse commits the winning request to in-service. The second pulse reads back an 8-bit vector. The vector's upper five bits are a base value that software programs into each controller. Its lower three bits are the level of the serviced input. When the cascade input wins, the vector comes from the secondary controller.

Software sets up each controller through a write-only byte port. A write to the command address with bit 4 set arms an initialization sequence. The next two writes to the data address (command address + 1) load the vector base and then the cascade word. Each controller has an end-of-interrupt strobe that retires its highest-priority in-service level.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, `intr` is low, `vec_out` is 00h, and no request is pending or in service.
- R2: Each controller has a command address: 20h for the primary and A0h for the secondary. A write to it with data bit 4 set arms that controller. The next write to the data address (21h or A1h) stores data bits [7:3] as the vector base and ignores bits [2:0]. The write after that stores the cascade word. A data-address write to a controller that is not armed changes nothing.
- R3: A rising edge on an `irq_in` line is latched as pending, and `intr` goes high within three clocks when the request is not blocked.
- R4: Within each controller the lowest-numbered request wins. In the primary controller, input 2 stands for the whole secondary controller.
- R5: `vec_out` carries {base, level} only while the second acknowledge pulse is high. It reads 00h at every other time, including during the first pulse.
- R6: When primary input 2 wins, the vector is {secondary base, secondary level}, where levels 0 to 7 correspond to `irq_in[8]` to `irq_in[15]`. With bases 08h and 70h, line 0 yields 08h and line 8 yields 70h.
- R7: The cascade path is enabled only when the primary cascade word equals 04h and the secondary cascade word equals 02h. While it is disabled, secondary requests stay pending but do not raise `intr`.
- R8: `irq_in[2]` has no effect, because that primary input is reserved for the cascade.
- R9: The first acknowledge pulse moves the winner from pending to in-service. When the cascade wins, this happens in both controllers. An in-service level blocks requests of equal and lower priority in its controller, while higher-priority requests can still interrupt.
- R10: An end-of-interrupt strobe clears the highest-priority in-service bit of its controller, which unblocks lower levels.
- R11: An acknowledge with no unblocked request returns {primary base, 111b} and leaves in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | I/O address of the write |
| wr_data | input | 8 | Write data |
| irq_in | input | 16 | Request lines; [7:0] primary, [15:8] secondary |
| ack | input | 1 | Acknowledge strobe, two pulses per interrupt |
| eoi_master | input | 1 | End-of-interrupt for the primary controller |
| eoi_slave | input | 1 | End-of-interrupt for the secondary controller |
| intr | output | 1 | Registered interrupt request to the processor |
| vec_out | output | 8 | Vector during the second acknowledge pulse, else 00h |

## Verification
The checker runs on every cycle. It confirms that the vector bus is zero whenever the acknowledge is low and that a commit sets the in-service bit of the winning level. It also checks that a cascade commit sets primary in-service bit 2, that in-service level 0 masks every primary request, and that each end-of-interrupt removes exactly one in-service bit. The bench scenarios cover the remaining behaviour: priority order between simultaneous requests, nesting of a higher request under an active one, vector values from each base, the two cascade-word gates, the ignored line 2, and the spurious-acknowledge vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE,
    ACK_FIRST,
    ACK_GAP,
    ACK_SECOND
  } ack_state_e;

  typedef enum logic [1:0] {
    CFG_RUN,
    CFG_W2,
    CFG_W3
  } cfg_state_e;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BASE_W = 5,
  parameter int ARM_BIT = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BASE_W-1:0] base_q,
  output logic [DATA_W-1:0] casc_q
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = CMD_ADDR + ADDR_W'(1);

  cfg_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CFG_RUN;
      base_q  <= '0;
      casc_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == CMD_ADDR && wr_data[ARM_BIT]) begin
        state_q <= CFG_W2;
      end else if (wr_addr == DATA_ADDR) begin
        case (state_q)
          CFG_W2: begin
            base_q  <= wr_data[DATA_W-1 -: BASE_W];
            state_q <= CFG_W3;
          end
          CFG_W3: begin
            casc_q  <= wr_data;
            state_q <= CFG_RUN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
  parameter int N = 8,
  parameter int LVL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     edge_in,
  input  logic [N-1:0]     level_in,
  input  logic             take,
  input  logic             eoi,
  output logic             has_req,
  output logic [LVL_W-1:0] win,
  output logic [N-1:0]     isr_q
);
  logic [N-1:0] prev_q, pend_q;
  logic [N-1:0] rise, allow, cand, win_oh, eoi_oh;
  logic         blocked, hit, ehit;

  always_comb begin
    rise    = edge_in & ~prev_q;
    allow   = '0;
    blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (isr_q[i]) blocked = 1'b1;
      allow[i] = !blocked;
    end
    cand    = (pend_q | level_in) & allow;
    has_req = |cand;
    win     = '0;
    win_oh  = '0;
    hit     = 1'b0;
    eoi_oh  = '0;
    ehit    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !hit) begin
        win       = LVL_W'(i);
        win_oh[i] = 1'b1;
        hit       = 1'b1;
      end
      if (isr_q[i] && !ehit) begin
        eoi_oh[i] = 1'b1;
        ehit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= edge_in;
      pend_q <= (pend_q & ~(take ? win_oh : '0)) | rise;
      isr_q  <= (isr_q & ~(eoi ? eoi_oh : '0)) | (take ? win_oh : '0);
    end
  end
endmodule

// File: rtl/irqc_ack.sv
module irqc_ack
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic first_take,
  output logic drive_vec
);
  ack_state_e state_q;

  assign first_take = (state_q == ACK_IDLE) && ack;
  assign drive_vec  = ack && (state_q == ACK_GAP || state_q == ACK_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ACK_IDLE;
    end else begin
      case (state_q)
        ACK_IDLE:   if (ack)  state_q <= ACK_FIRST;
        ACK_FIRST:  if (!ack) state_q <= ACK_GAP;
        ACK_GAP:    if (ack)  state_q <= ACK_SECOND;
        ACK_SECOND: if (!ack) state_q <= ACK_IDLE;
        default:    state_q <= ACK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CASCADE_IN = 2,
  parameter int ARM_BIT = 4,
  parameter logic [ADDR_W-1:0] MASTER_CMD_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] SLAVE_CMD_ADDR = 8'hA0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [2*NUM_IN-1:0]   irq_in,
  input  logic                  ack,
  input  logic                  eoi_master,
  input  logic                  eoi_slave,
  output logic                  intr,
  output logic [DATA_W-1:0]     vec_out
);
  localparam int LVL_W = $clog2(NUM_IN);
  localparam int BASE_W = DATA_W - LVL_W;
  localparam int M = 0;
  localparam int S = 1;
  localparam logic [NUM_IN-1:0] CASC_BIT = NUM_IN'(1) << CASCADE_IN;
  localparam logic [DATA_W-1:0] MASTER_W3 = DATA_W'(1) << CASCADE_IN;
  localparam logic [DATA_W-1:0] SLAVE_W3 = DATA_W'(CASCADE_IN);

  logic [BASE_W-1:0] cfg_base [2];
  logic [DATA_W-1:0] cfg_w3   [2];
  logic [NUM_IN-1:0] core_edge [2];
  logic [NUM_IN-1:0] core_level[2];
  logic [NUM_IN-1:0] core_isr  [2];
  logic [LVL_W-1:0]  core_win  [2];
  logic              core_has  [2];
  logic              core_take [2];
  logic              core_eoi  [2];

  logic              first_take, drive_vec, casc_en, casc_win;
  logic [DATA_W-1:0] vec_next, vec_q;
  logic              intr_q;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_ctl
      irqc_cfg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BASE_W  (BASE_W),
        .ARM_BIT (ARM_BIT),
        .CMD_ADDR((g == M) ? MASTER_CMD_ADDR : SLAVE_CMD_ADDR)
      ) i_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .base_q (cfg_base[g]),
        .casc_q (cfg_w3[g])
      );

      irqc_core #(
        .N    (NUM_IN),
        .LVL_W(LVL_W)
      ) i_core (
        .clk     (clk),
        .rst     (rst),
        .edge_in (core_edge[g]),
        .level_in(core_level[g]),
        .take    (core_take[g]),
        .eoi     (core_eoi[g]),
        .has_req (core_has[g]),
        .win     (core_win[g]),
        .isr_q   (core_isr[g])
      );
    end
  endgenerate

  irqc_ack i_ack (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .first_take(first_take),
    .drive_vec (drive_vec)
  );

  assign casc_en       = (cfg_w3[M] == MASTER_W3) && (cfg_w3[S] == SLAVE_W3);
  assign core_edge[S]  = irq_in[2*NUM_IN-1:NUM_IN];
  assign core_level[S] = '0;
  assign core_edge[M]  = irq_in[NUM_IN-1:0] & ~CASC_BIT;
  assign core_level[M] = (casc_en && core_has[S]) ? CASC_BIT : '0;

  assign casc_win      = core_win[M] == LVL_W'(CASCADE_IN);
  assign core_take[M]  = first_take && core_has[M];
  assign core_take[S]  = core_take[M] && casc_win;
  assign core_eoi[M]   = eoi_master;
  assign core_eoi[S]   = eoi_slave;

  always_comb begin
    if (!core_has[M])  vec_next = {cfg_base[M], {LVL_W{1'b1}}};
    else if (casc_win) vec_next = {cfg_base[S], core_win[S]};
    else               vec_next = {cfg_base[M], core_win[M]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      intr_q <= 1'b0;
    end else begin
      intr_q <= core_has[M];
      if (first_take) vec_q <= vec_next;
    end
  end

  assign intr    = intr_q;
  assign vec_out = drive_vec ? vec_q : '0;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N = 8,
  parameter int LVL_W = 3,
  parameter int DATA_W = 8,
  parameter int CASC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic [DATA_W-1:0] vec_out,
  input logic              m_take,
  input logic              s_take,
  input logic [LVL_W-1:0]  m_win,
  input logic [N-1:0]      m_isr,
  input logic              m_has,
  input logic              eoi_m
);
  AST_VEC_ZERO_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !ack |-> vec_out == '0); // R5

  AST_TAKE_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    m_take |=> m_isr[$past(m_win)]); // R9

  AST_CASC_TAKE_MASTER_BIT: assert property (@(posedge clk) disable iff (rst)
    s_take |=> m_isr[CASC]); // R6

  AST_TOP_LEVEL_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
    m_isr[0] |-> !m_has); // R9

  AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
    (eoi_m && !m_take && m_isr != '0) |=>
      ($countones(m_isr) + 1 == $countones($past(m_isr)))); // R10
endmodule

bind cascade_irq_ctrl irqc_chk #(
  .N     (NUM_IN),
  .LVL_W (LVL_W),
  .DATA_W(DATA_W),
  .CASC  (CASCADE_IN)
) i_chk (
  .clk    (clk),
  .rst    (rst),
  .ack    (ack),
  .vec_out(vec_out),
  .m_take (core_take[0]),
  .s_take (core_take[1]),
  .m_win  (core_win[0]),
  .m_isr  (core_isr[0]),
  .m_has  (core_has[0]),
  .eoi_m  (eoi_master)
);

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] irq_in = '0;
  logic        ack = 1'b0;
  logic        eoi_master = 1'b0;
  logic        eoi_slave = 1'b0;
  logic        intr;
  logic [7:0]  vec_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit win = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_in(irq_in), .ack(ack), .eoi_master(eoi_master), .eoi_slave(eoi_slave),
    .intr(intr), .vec_out(vec_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected vector during each second acknowledge pulse
  always @(negedge clk) begin
    if (win) begin
      if (exp_q.size() == 0) chk("R5 unexpected vector window", vec_out, 8'h00);
      else chk(tag_q.pop_front(), vec_out, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] m);
    @(posedge clk); #1 irq_in = irq_in | m;
    @(posedge clk); #1 irq_in = irq_in & ~m;
  endtask

  task automatic eoi(input bit m, input bit s);
    @(posedge clk); #1 eoi_master = m; eoi_slave = s;
    @(posedge clk); #1 eoi_master = 1'b0; eoi_slave = 1'b0;
  endtask

  task automatic check_intr(input string tag, input logic exp);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tag, {7'b0, intr}, {7'b0, exp});
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp_vec);
    exp_q.push_back(exp_vec);
    tag_q.push_back(tag);
    @(posedge clk); #1 ack = 1'b1;
    @(negedge clk); chk({tag, " R5 zero in first pulse"}, vec_out, 8'h00);
    @(posedge clk); #1 ack = 1'b0;
    @(posedge clk); #1 ack = 1'b1; win = 1'b1;
    @(posedge clk); #1 ack = 1'b0; win = 1'b0;
    @(negedge clk); chk({tag, " R5 zero after pulse"}, vec_out, 8'h00);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 intr after reset", {7'b0, intr}, 8'h00);
    chk("R1 vec_out after reset", vec_out, 8'h00);

    // R2 setup: base bits [2:0] written non-zero must be dropped
    wr(8'h20, 8'h10); wr(8'h21, 8'h0F); wr(8'h21, 8'h04);
    wr(8'hA0, 8'h10); wr(8'hA1, 8'h70); wr(8'hA1, 8'h02);
    check_intr("R1 no intr before requests", 1'b0);

    // R8: line 2 is reserved
    pulse(16'h0004);
    check_intr("R8 irq_in[2] ignored", 1'b0);

    // R3 R4 R9 R10: priority, nesting, end of interrupt
    pulse(16'h0028);
    check_intr("R3 intr raised", 1'b1);
    do_ack("R4 R2 lowest of 3,5", 8'h0B);
    check_intr("R9 level 5 blocked by 3", 1'b0);
    pulse(16'h0002);
    check_intr("R9 higher level 1 nests", 1'b1);
    do_ack("R9 nested vector", 8'h09);
    eoi(1'b1, 1'b0);
    check_intr("R10 eoi clears only level 1", 1'b0);
    eoi(1'b1, 1'b0);
    check_intr("R10 eoi unblocks level 5", 1'b1);
    do_ack("R10 level 5 vector", 8'h0D);
    eoi(1'b1, 1'b0);

    // R6: cascade
    pulse(16'h0100);
    check_intr("R6 cascade raises intr", 1'b1);
    do_ack("R6 line 8 vector", 8'h70);
    pulse(16'h0200);
    check_intr("R9 slave in-service blocks line 9", 1'b0);
    eoi(1'b1, 1'b1);
    check_intr("R10 both eoi unblock line 9", 1'b1);
    do_ack("R6 line 9 vector", 8'h71);
    eoi(1'b1, 1'b1);

    pulse(16'h1400);
    do_ack("R4 slave lowest of 10,12", 8'h72);
    eoi(1'b1, 1'b1);
    do_ack("R4 slave next 12", 8'h74);
    eoi(1'b1, 1'b1);

    pulse(16'h0201);
    do_ack("R4 line 0 beats cascade", 8'h08);
    eoi(1'b1, 1'b0);
    do_ack("R4 cascade after line 0", 8'h71);
    eoi(1'b1, 1'b1);

    // R11: spurious acknowledge
    check_intr("R11 idle before spurious ack", 1'b0);
    do_ack("R11 spurious vector", 8'h0F);
    check_intr("R11 no in-service left behind", 1'b0);
    pulse(16'h0010);
    do_ack("R11 line 4 after spurious", 8'h0C);
    eoi(1'b1, 1'b0);

    // R7: cascade gate by cascade word
    wr(8'h20, 8'h10); wr(8'h21, 8'h08); wr(8'h21, 8'h00);
    pulse(16'h0800);
    check_intr("R7 cascade disabled", 1'b0);
    wr(8'h20, 8'h10); wr(8'h21, 8'h50); wr(8'h21, 8'h04);
    check_intr("R7 cascade re-enabled", 1'b1);
    do_ack("R7 held line 11 vector", 8'h73);
    eoi(1'b1, 1'b1);

    // R2: new base, and unarmed data write ignored
    pulse(16'h0040);
    do_ack("R2 new base", 8'h56);
    eoi(1'b1, 1'b0);
    wr(8'h21, 8'h30);
    pulse(16'h0040);
    do_ack("R2 unarmed write ignored", 8'h56);
    eoi(1'b1, 1'b0);

    chk("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule